// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This core moves byte-wide channels between eight serial input streams and eight serial output streams. Every frame carries 128 channels on each stream. All streams share one bit rate, which is half the master clock. The core turns each input stream into bytes and stores every byte by frame, stream and channel. For each output stream and channel, a connection word names the byte to send. That byte is either a stored input byte from any stream and channel, or a literal byte held in the word itself. Each word also chooses its own throughput delay and carries per-channel drive, loopback and control-level bits.

A host programs the connection words and reads back stored bytes through a simple synchronous port. The host port also controls a standby bit. This bit and a global drive-enable input can silence every output at once. Frame and channel timing run freely from reset. Slot 0 of frame 0 is the first slot after reset is released.

Top module: `tsi_switch`

## Requirements
- R1: After reset the slot counters start at stream slot 0, bit 0. `tx_en` stays all-zero and `ctl_lvl` stays zero for the whole first frame (frame 0), and `h_rdata` reads zero.
- R2: Each input bit is sampled once per bit cell, in the first master-clock cycle of the cell, most significant bit first. Eight bits make the byte of that stream and channel. A host read with `h_sel` = 1 at address stream*128+channel returns {8'h00, byte} from the previous complete frame on the cycle after the request.
- R3: Connection mode (word bit 11 = 0) sends the stored byte from the source given by bits [9:7] (stream) and [6:0] (channel). Any number of outputs may name the same source.
- R4: With bit 12 = 0 (variable delay), output channel o takes source channel i from the same frame if o >= i+3. Otherwise it takes the byte of the previous frame.
- R5: With bit 12 = 1 (constant delay), an output in frame F always carries the source byte received in frame F-2, whatever the channel pair.
- R6: Processor mode (bit 11 = 1) sends word bits [7:0] in every frame. A host rewrite takes effect from the next slot fetched after the write.
- R7: Word bit 13 enables `tx_en` for that output channel for its whole slot. When bit 13 is 0 the channel is tri-stated.
- R8: `drive_en` low, or the standby bit (written with `h_sel` = 2, data bit 0) set, forces every `tx_en` low whatever the per-channel bits say.
- R9: When word bit 14 is set on output stream n, channel m, the byte sent there replaces the received byte of stream n, channel m in storage.
- R10: `ctl_lvl` of each stream drives word bit 15 of the channel currently being sent.
- R11: Each output bit is held for two master cycles, most significant bit first. The byte for a slot is fetched at the last cycle of the previous slot.
- R12: A host read with `h_sel` = 0 returns the 16-bit connection word. A read with `h_sel` = 2 returns the standby bit in bit 0. Read data holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, twice the bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx | input | 8 | Serial input bit per stream |
| drive_en | input | 1 | Global output drive enable, active high |
| h_en | input | 1 | Host access strobe |
| h_we | input | 1 | Host write (1) or read (0) |
| h_sel | input | 2 | Host target: 0 connection word, 1 stored byte, 2 standby bit |
| h_addr | input | 10 | Host address, stream*128+channel |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data, registered |
| tx_data | output | 8 | Serial output bit per stream |
| tx_en | output | 8 | Per-stream output drive enable for the current channel |
| ctl_lvl | output | 8 | Per-channel control level per stream |

## Verification
Three things are hard to reach from the ports. The first is the boundary of the variable-delay rule, especially where it wraps across the frame edge. The second is constant delay reading from two frames back. The third is loopback overwriting stored bytes. The stimulus gives every output stream a different routing style: same-channel, offset by exactly three, offset by five with constant delay, broadcast, literal with loopback, and a reader of the looped stream. Every input byte is a distinct function of stream, channel and frame, so a wrong bank or frame shows up as a wrong byte. Drive-enable pulses, standby writes, a mid-frame literal rewrite and host reads are placed at fixed slots in later frames.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    // connection word layout
    typedef struct packed {
        logic        lvl;    // control level driven during the slot
        logic        lpbk;   // feed sent byte back into storage
        logic        oe;     // channel drive enable
        logic        cdly;   // constant (1) or variable (0) delay
        logic        proc;   // literal byte (1) or routed byte (0)
        logic [10:0] src;    // source address or literal in [7:0]
    } cword_t;

    typedef enum logic [1:0] {
        SEL_CONN = 2'd0,
        SEL_DATA = 2'd1,
        SEL_STBY = 2'd2
    } hsel_e;

    function automatic logic [1:0] bank_next(input logic [1:0] b);
        return (b == 2'd2) ? 2'd0 : b + 2'd1;
    endfunction

    function automatic logic [1:0] bank_prev(input logic [1:0] b);
        return (b == 2'd0) ? 2'd2 : b - 2'd1;
    endfunction

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
    parameter int CHANNELS = 128,
    parameter int CW       = $clog2(CHANNELS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          ph,
    output logic [2:0]    bitn,
    output logic [CW-1:0] chan,
    output logic [1:0]    fr,
    output logic          primed,
    output logic [CW-1:0] nchan,
    output logic [1:0]    nfr
);
    import tsi_pkg::*;

    localparam logic [CW-1:0] LAST = CW'(CHANNELS - 1);

    typedef struct packed {
        logic          ph;
        logic [2:0]    bitn;
        logic [CW-1:0] chan;
        logic [1:0]    fr;
        logic          primed;
    } tim_t;

    tim_t s_q, s_d;

    always_comb begin
        nchan = (s_q.chan == LAST) ? '0 : s_q.chan + 1'b1;
        nfr   = (s_q.chan == LAST) ? bank_next(s_q.fr) : s_q.fr;
        s_d    = s_q;
        s_d.ph = ~s_q.ph;
        if (s_q.ph) begin
            s_d.bitn = s_q.bitn + 3'd1;
            if (s_q.bitn == 3'd7) begin
                s_d.chan = nchan;
                s_d.fr   = nfr;
                if (s_q.chan == LAST) s_d.primed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ph     = s_q.ph;
    assign bitn   = s_q.bitn;
    assign chan   = s_q.chan;
    assign fr     = s_q.fr;
    assign primed = s_q.primed;

    AST_PRIMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.primed |=> s_q.primed); // R1
    AST_CHAN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.chan != $past(s_q.chan)) |-> (s_q.bitn == 3'd0 && !s_q.ph)); // R11
    AST_FRAME_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fr != 2'd3); // R5

endmodule

// File: rtl/tsi_rx.sv
module tsi_rx #(
    parameter int STREAMS  = 8,
    parameter int CHANNELS = 128,
    parameter int SW       = $clog2(STREAMS),
    parameter int CW       = $clog2(CHANNELS),
    parameter int AW       = SW + CW
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ph,
    input  logic [2:0]                   bitn,
    input  logic [CW-1:0]                chan,
    input  logic [1:0]                   fr,
    input  logic [STREAMS-1:0]           rx_bit,
    input  logic [STREAMS-1:0][1:0]      rd_bank,
    input  logic [STREAMS-1:0][AW-1:0]   rd_addr,
    output logic [STREAMS-1:0][7:0]      rd_byte,
    input  logic [AW-1:0]                h_addr,
    output logic [7:0]                   h_byte
);
    import tsi_pkg::*;

    localparam int DEPTH = STREAMS * CHANNELS;

    logic [STREAMS-1:0][6:0] sh_d, sh_q;
    logic [7:0] mem [3][DEPTH];

    always_comb begin
        sh_d = sh_q;
        if (!ph) begin
            for (int s = 0; s < STREAMS; s++) sh_d[s] = {sh_q[s][5:0], rx_bit[s]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // byte complete on the sampling cycle of the last bit
    always_ff @(posedge clk) begin
        if (!ph && bitn == 3'd7) begin
            for (int s = 0; s < STREAMS; s++)
                mem[fr][{SW'(s), chan}] <= {sh_q[s], rx_bit[s]};
        end
    end

    always_comb begin
        for (int s = 0; s < STREAMS; s++) rd_byte[s] = mem[rd_bank[s]][rd_addr[s]];
        h_byte = mem[bank_prev(fr)][h_addr];
    end

endmodule

// File: rtl/tsi_conn.sv
module tsi_conn #(
    parameter int STREAMS = 8,
    parameter int DEPTH   = 1024,
    parameter int AW      = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        h_wr,
    input  logic [AW-1:0]               h_addr,
    input  logic [15:0]                 h_wdata,
    output logic [15:0]                 h_word,
    input  logic [STREAMS-1:0][AW-1:0]  rd_addr,
    output logic [STREAMS-1:0][15:0]    rd_word
);
    logic [15:0] cm [DEPTH];

    always_ff @(posedge clk) begin
        if (h_wr) cm[h_addr] <= h_wdata;
    end

    always_comb begin
        h_word = cm[h_addr];
        for (int s = 0; s < STREAMS; s++) rd_word[s] = cm[rd_addr[s]];
    end

endmodule

// File: rtl/tsi_tx.sv
module tsi_tx #(
    parameter int STREAMS  = 8,
    parameter int CHANNELS = 128,
    parameter int SW       = $clog2(STREAMS),
    parameter int CW       = $clog2(CHANNELS),
    parameter int AW       = SW + CW
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ph,
    input  logic [2:0]                   bitn,
    input  logic [CW-1:0]                nchan,
    input  logic [1:0]                   nfr,
    input  logic [STREAMS-1:0][15:0]     cword,
    input  logic [STREAMS-1:0][7:0]      dm_byte,
    output logic [STREAMS-1:0][AW-1:0]   cm_addr,
    output logic [STREAMS-1:0][1:0]      dm_bank,
    output logic [STREAMS-1:0][AW-1:0]   dm_addr,
    output logic [STREAMS-1:0]           tx_data,
    output logic [STREAMS-1:0]           oe,
    output logic [STREAMS-1:0]           lpbk,
    output logic [STREAMS-1:0]           lvl
);
    import tsi_pkg::*;

    typedef struct packed {
        logic [STREAMS-1:0][7:0] sh;
        logic [STREAMS-1:0]      oe;
        logic [STREAMS-1:0]      lp;
        logic [STREAMS-1:0]      lv;
    } txs_t;

    txs_t s_q, s_d;
    cword_t w;
    logic [CW:0] reach;
    logic [STREAMS-1:0][7:0] pick;

    always_comb begin
        s_d = s_q;
        w = '0;
        reach = '0;
        for (int s = 0; s < STREAMS; s++) begin
            cm_addr[s] = {SW'(s), nchan};
            w          = cword_t'(cword[s]);
            dm_addr[s] = AW'(w.src);
            reach      = {1'b0, w.src[CW-1:0]} + (CW+1)'(3);
            if (w.cdly)                    dm_bank[s] = bank_next(nfr);
            else if (reach <= {1'b0, nchan}) dm_bank[s] = nfr;
            else                           dm_bank[s] = bank_prev(nfr);
            pick[s] = w.proc ? w.src[7:0] : dm_byte[s];
            if (ph && bitn == 3'd7) begin
                s_d.sh[s] = pick[s];
                s_d.oe[s] = w.oe;
                s_d.lp[s] = w.lpbk;
                s_d.lv[s] = w.lvl;
            end else if (ph) begin
                s_d.sh[s] = {s_q.sh[s][6:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        for (int s = 0; s < STREAMS; s++) tx_data[s] = s_q.sh[s][7];
    end
    assign oe   = s_q.oe;
    assign lpbk = s_q.lp;
    assign lvl  = s_q.lv;

    AST_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ph |-> $stable(s_q.sh)); // R11
    AST_CTRL_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.oe != $past(s_q.oe)) |-> (bitn == 3'd0 && !ph)); // R7

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
    parameter int STREAMS  = 8,
    parameter int CHANNELS = 128
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic [STREAMS-1:0]                             rx,
    input  logic                                           drive_en,
    input  logic                                           h_en,
    input  logic                                           h_we,
    input  logic [1:0]                                     h_sel,
    input  logic [$clog2(STREAMS)+$clog2(CHANNELS)-1:0]    h_addr,
    input  logic [15:0]                                    h_wdata,
    output logic [15:0]                                    h_rdata,
    output logic [STREAMS-1:0]                             tx_data,
    output logic [STREAMS-1:0]                             tx_en,
    output logic [STREAMS-1:0]                             ctl_lvl
);
    import tsi_pkg::*;

    localparam int SW = $clog2(STREAMS);
    localparam int CW = $clog2(CHANNELS);
    localparam int AW = SW + CW;

    typedef struct packed {
        logic        stby;
        logic [15:0] rdata;
    } top_t;

    top_t s_q, s_d;

    logic          ph, primed;
    logic [2:0]    bitn;
    logic [CW-1:0] chan, nchan;
    logic [1:0]    fr, nfr;

    logic [STREAMS-1:0][AW-1:0] cm_addr, dm_addr;
    logic [STREAMS-1:0][1:0]    dm_bank;
    logic [STREAMS-1:0][15:0]   cword;
    logic [STREAMS-1:0][7:0]    dm_byte;
    logic [STREAMS-1:0]         oe, lpbk, lvl, rx_eff;
    logic [15:0]                h_word;
    logic [7:0]                 h_byte;

    tsi_timing #(.CHANNELS(CHANNELS), .CW(CW)) u_timing (
        .clk(clk), .rst_n(rst_n), .ph(ph), .bitn(bitn), .chan(chan), .fr(fr),
        .primed(primed), .nchan(nchan), .nfr(nfr)
    );

    assign rx_eff = (lpbk & tx_data) | (~lpbk & rx);

    tsi_rx #(.STREAMS(STREAMS), .CHANNELS(CHANNELS), .SW(SW), .CW(CW), .AW(AW)) u_rx (
        .clk(clk), .rst_n(rst_n), .ph(ph), .bitn(bitn), .chan(chan), .fr(fr),
        .rx_bit(rx_eff), .rd_bank(dm_bank), .rd_addr(dm_addr), .rd_byte(dm_byte),
        .h_addr(h_addr), .h_byte(h_byte)
    );

    tsi_conn #(.STREAMS(STREAMS), .DEPTH(STREAMS*CHANNELS), .AW(AW)) u_conn (
        .clk(clk), .h_wr(h_en && h_we && h_sel == SEL_CONN), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_word(h_word), .rd_addr(cm_addr), .rd_word(cword)
    );

    tsi_tx #(.STREAMS(STREAMS), .CHANNELS(CHANNELS), .SW(SW), .CW(CW), .AW(AW)) u_tx (
        .clk(clk), .rst_n(rst_n), .ph(ph), .bitn(bitn), .nchan(nchan), .nfr(nfr),
        .cword(cword), .dm_byte(dm_byte), .cm_addr(cm_addr), .dm_bank(dm_bank),
        .dm_addr(dm_addr), .tx_data(tx_data), .oe(oe), .lpbk(lpbk), .lvl(lvl)
    );

    always_comb begin
        s_d = s_q;
        if (h_en && h_we && h_sel == SEL_STBY) s_d.stby = h_wdata[0];
        if (h_en && !h_we) begin
            case (h_sel)
                SEL_CONN: s_d.rdata = h_word;
                SEL_DATA: s_d.rdata = {8'h00, h_byte};
                SEL_STBY: s_d.rdata = {15'h0000, s_q.stby};
                default:  s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign h_rdata = s_q.rdata;
    assign tx_en   = (primed && drive_en && !s_q.stby) ? oe : '0;
    assign ctl_lvl = primed ? lvl : '0;

    AST_QUIET_UNTIL_PRIMED: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |-> (tx_en == '0)); // R1
    AST_STANDBY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stby |-> (tx_en == '0)); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !h_en |=> $stable(h_rdata)); // R12

endmodule

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;
    localparam int S  = 8;
    localparam int C  = 128;
    localparam int FR = C * 16;
    localparam int NF = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n;
    logic [S-1:0] rx;
    logic         drive_en;
    logic         h_en, h_we;
    logic [1:0]   h_sel;
    logic [9:0]   h_addr;
    logic [15:0]  h_wdata;
    logic [15:0]  h_rdata;
    logic [S-1:0] tx_data, tx_en, ctl_lvl;

    tsi_switch u_tsi_switch (
        .clk(clk), .rst_n(rst_n), .rx(rx), .drive_en(drive_en),
        .h_en(h_en), .h_we(h_we), .h_sel(h_sel), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rdata(h_rdata),
        .tx_data(tx_data), .tx_en(tx_en), .ctl_lvl(ctl_lvl)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    int          recv [0:NF][0:S-1][0:C-1];
    logic [15:0] mconn [0:S*C-1];
    int          exp_byte [S];
    bit          exp_oe [S], exp_lp [S], exp_lv [S];
    bit          m_stby;
    bit          rd_pend;
    int          rd_exp;
    string       rd_tag;
    string       stag [S] = '{"R4", "R4", "R5", "R6", "R3", "R7", "R9", "R9"};

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    function automatic int pat(input int s, input int c, input int f);
        return (s * 37 + c * 3 + f * 11 + 5) & 255;
    endfunction

    // word: [15] lvl [14] loopback [13] oe [12] constant [11] literal [9:7] stream [6:0] channel
    function automatic logic [15:0] cfg(input int s, input int c);
        logic [15:0] w;
        case (s)
            0: w = 16'h2000 | 16'(1 * 128 + c);
            1: w = 16'h2000 | 16'(2 * 128 + ((c + 125) % 128));
            2: w = 16'h3000 | 16'(3 * 128 + ((c + 5) % 128));
            3: w = 16'h2800 | 16'((c ^ 8'hA5) & 255) | ((c % 2 == 1) ? 16'h8000 : 16'h0);
            4: w = 16'h2000 | 16'(0 * 128 + 7);
            5: w = (((c / 2) % 2 == 1) ? 16'h2000 : 16'h0) | 16'(4 * 128 + c);
            6: w = 16'h2800 | 16'((c + 1) & 255) | ((c % 4 == 0) ? 16'h4000 : 16'h0);
            default: w = 16'hA000 | 16'(6 * 128 + ((c + 10) % 128));
        endcase
        return w;
    endfunction

    initial begin
        #(64'd200000 * 10);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; drive_en = 1'b1; h_en = 1'b0; h_we = 1'b0; h_sel = 2'd0;
        h_addr = '0; h_wdata = '0; m_stby = 1'b0; rd_pend = 1'b0; rd_exp = 0;
        for (int f = 0; f <= NF; f++)
            for (int s = 0; s < S; s++)
                for (int c = 0; c < C; c++) recv[f][s][c] = -1;
        for (int s = 0; s < S; s++) begin
            exp_byte[s] = -1; exp_oe[s] = 0; exp_lp[s] = 0; exp_lv[s] = 0;
            rx[s] = pat(s, 0, 0) >> 7;
        end
        repeat (3) @(negedge clk);
        chk(tx_en == '0, "R1 reset tx_en", int'(tx_en), 0);
        chk(h_rdata == '0, "R1 reset h_rdata", int'(h_rdata), 0);
        chk(ctl_lvl == '0, "R1 reset ctl_lvl", int'(ctl_lvl), 0);
        rst_n = 1'b1;

        for (int k = 0; k < NF * FR; k++) begin
            automatic int f  = k / FR;
            automatic int o  = (k / 16) % C;
            automatic int b  = (k / 2) % 8;
            automatic int ph = k % 2;
            automatic int kn = k + 1;

            // R11: every bit is compared in both master-clock cycles of its cell
            for (int s = 0; s < S; s++) begin
                automatic bit en = (f >= 1) && exp_oe[s] && drive_en && !m_stby;
                automatic string etag = (f == 0) ? "R1 en" :
                                        (!drive_en || m_stby) ? "R8 en" : "R7 en";
                chk(tx_en[s] == en, etag, int'(tx_en[s]), int'(en));
                if (en && exp_byte[s] >= 0)
                    chk(tx_data[s] == exp_byte[s][7 - b], stag[s],
                        int'(tx_data[s]), int'(exp_byte[s][7 - b]));
                chk(ctl_lvl[s] == ((f >= 1) ? exp_lv[s] : 1'b0), "R10 lvl",
                    int'(ctl_lvl[s]), int'((f >= 1) ? exp_lv[s] : 1'b0));
            end
            if (rd_pend) begin
                chk(int'(h_rdata) == rd_exp, rd_tag, int'(h_rdata), rd_exp);
                rd_pend = 1'b0;
            end

            // stored byte of slot o (R2, R9)
            if (ph == 0 && b == 7) begin
                for (int s = 0; s < S; s++) begin
                    if (f == 0)         recv[f][s][o] = -1;
                    else if (exp_lp[s]) recv[f][s][o] = exp_byte[s];
                    else                recv[f][s][o] = pat(s, o, f);
                end
            end

            // fetch for the next slot
            if (ph == 1 && b == 7) begin
                automatic int no = (o + 1) % C;
                automatic int nf = (o == C - 1) ? f + 1 : f;
                for (int s = 0; s < S; s++) begin
                    automatic logic [15:0] w = mconn[s * C + no];
                    if (k < 1024) begin
                        exp_byte[s] = -1; exp_oe[s] = 0; exp_lp[s] = 0; exp_lv[s] = 0;
                    end else begin
                        exp_oe[s] = w[13]; exp_lp[s] = w[14]; exp_lv[s] = w[15];
                        if (w[11]) exp_byte[s] = int'(w[7:0]);
                        else begin
                            automatic int si = int'(w[9:7]);
                            automatic int ii = int'(w[6:0]);
                            automatic int sf = w[12] ? nf - 2 : ((ii + 3 <= no) ? nf : nf - 1);
                            exp_byte[s] = (sf >= 0) ? recv[sf][si][ii] : -1;
                        end
                    end
                end
            end

            // host stimulus for the next cycle
            h_en = 1'b0; h_we = 1'b0; h_sel = 2'd0;
            if (k < 1024) begin
                h_en = 1'b1; h_we = 1'b1; h_sel = 2'd0; h_addr = 10'(k);
                h_wdata = cfg(k / C, k % C);
                mconn[k] = h_wdata;
            end
            if (k == 4 * FR + 300 || k == 4 * FR + 900) begin
                h_en = 1'b1; h_we = 1'b1; h_sel = 2'd2;
                h_wdata = (k == 4 * FR + 300) ? 16'h0001 : 16'h0000;
                m_stby = h_wdata[0];
            end
            if (k == 5 * FR + 40) begin
                // R6: literal rewrite of stream 3 channel 50 mid-frame
                h_en = 1'b1; h_we = 1'b1; h_sel = 2'd0; h_addr = 10'(3 * C + 50);
                h_wdata = 16'hA83C;
                mconn[3 * C + 50] = h_wdata;
            end
            if (k == 6 * FR + 100) begin
                h_en = 1'b1; h_sel = 2'd1; h_addr = 10'(2 * C + 5);
                rd_pend = 1'b1; rd_exp = pat(2, 5, 5); rd_tag = "R2 stored byte";
            end
            if (k == 6 * FR + 110) begin
                h_en = 1'b1; h_sel = 2'd0; h_addr = 10'(3 * C + 50);
                rd_pend = 1'b1; rd_exp = 16'hA83C; rd_tag = "R12 word read";
            end
            if (k == 6 * FR + 120) begin
                h_en = 1'b1; h_sel = 2'd2;
                rd_pend = 1'b1; rd_exp = 0; rd_tag = "R12 standby read";
            end
            if (k == 6 * FR + 130) begin
                h_en = 1'b1; h_sel = 2'd1; h_addr = 10'(6 * C + 8);
                rd_pend = 1'b1; rd_exp = 9; rd_tag = "R9 looped byte";
            end

            // R8: drive enable pulse in frame 3
            drive_en = !((kn / FR) == 3 && ((kn / 16) % C) >= 30 && ((kn / 16) % C) < 46);
            for (int s = 0; s < S; s++)
                rx[s] = pat(s, (kn / 16) % C, kn / FR) >> (7 - (kn / 2) % 8);

            @(negedge clk);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule